// File: doc/BRIEF.md
# Color Panel Raster Timing Generator

This block scans a small color LCD panel that has column and row drivers but no frame controller, so it has to be refreshed continuously at one pixel per dot clock. It counts the column and row of the pixel now being sent and publishes that position, so upstream logic can supply the matching pixel on the same clock. From the counts it derives a horizontal sync, a vertical sync and a pixel-enable flag. It also gates the 9-bit color input, which is 3 bits each of red, green and blue, so that nothing but zeros reaches the panel during blanking. Stray data in blanking makes the panel shift its image.

Each sync pulse covers its whole blanking interval. Horizontal sync is active from the first dot after the last visible pixel of a line until the dot just before the next visible pixel. Vertical sync is active on every line after the last visible row, up to the line before the first visible row of the next frame. The visible size, the blanking lengths and the sync polarity are all parameters. The defaults are 240x160 visible, 40 blank dots per line, 10 blank lines per frame, and active-low syncs.

Top module: `tft_raster_gen`

## Requirements
- R1: While rst_n is low, col and row read 0, both sync outputs sit at their inactive level, pix_en is 0 and the color outputs are 0.
- R2: col counts up by one on each dot clock, from 0 to H_VIS+H_BLANK-1, and then wraps to 0.
- R3: row advances by one only on the clock where col wraps, and it wraps from V_VIS+V_BLANK-1 to 0.
- R4: hsync is at its active level exactly when col >= H_VIS.
- R5: vsync is at its active level exactly when row >= V_VIS.
- R6: pix_en is 1 exactly when col < H_VIS and row < V_VIS.
- R7: When pix_en is 1, the color outputs equal the color inputs: red in bits [8:6], green in [5:3], blue in [2:0].
- R8: When pix_en is 0, the color outputs are all zeros whatever the color inputs are.
- R9: With SYNC_ACTIVE_HIGH=0 the active sync level is 0, and with SYNC_ACTIVE_HIGH=1 it is 1.
- R10: All outputs are combinational in the current position, so col, row, syncs, pix_en and the gated color all refer to the same dot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rgb_in | input | 9 | Color for the current position, R[8:6] G[5:3] B[2:0] |
| hsync | output | 1 | Horizontal sync, polarity set by parameter |
| vsync | output | 1 | Vertical sync, polarity set by parameter |
| col | output | CW | Current column |
| row | output | RW | Current row |
| pix_en | output | 1 | Visible-pixel flag |
| rgb_out | output | 9 | Color gated to zero outside the visible area |

## Verification
The column wrap and the row wrap land on the same clock at the last dot of the last blank line. That dot also takes both syncs from active to inactive and raises pix_en at the same time. The bench runs a small configuration over several complete frames, so it passes through this corner repeatedly. On every dot it compares the outputs with a position model kept by arithmetic in the bench, and checks that the first dot of each new frame reads (0,0) with syncs inactive and the input color passed through. Both polarities are built and swept.

// File: rtl/tft_raster_pkg.sv
// Shared helpers for the raster generator.
// Assumes: widths are derived from totals at elaboration.
package tft_raster_pkg;
    localparam int COLOR_W = 9;

    // Bits needed to hold values 0..n-1 (at least 1).
    function automatic int cnt_w(input int n);
        int w;
        w = 1;
        while ((1 << w) < n) w++;
        return w;
    endfunction
endpackage

// File: rtl/tft_axis_counter.sv
// One wrapping position counter (column or row).
// Counts when adv is high, and wraps to zero after LIMIT-1.
// wrap flags the cycle on which a counting step returns to zero.
// Assumes: synchronous active-low reset to zero.
module tft_axis_counter #(
    parameter int LIMIT = 280,
    parameter int W     = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    // wrap is high when the counter is at its last value and is stepping.
    always_comb wrap = adv && (cnt == LAST);

    // Step the counter, or return it to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (wrap) cnt <= '0;
        else if (adv)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tft_sync_decode.sv
// Turns one axis position into a blanking flag and a sync level.
// The sync is active across the whole blanking region of the axis.
// Assumes: the sync is held inactive while in reset.
module tft_sync_decode #(
    parameter int VIS         = 240,
    parameter int W           = 9,
    parameter bit ACTIVE_HIGH = 1'b0
) (
    input  logic         rst_n,
    input  logic [W-1:0] pos,
    output logic         visible,
    output logic         sync
);
    localparam logic [W-1:0] VIS_V = W'(VIS);

    // Visible when the position is below the visible extent.
    always_comb visible = (pos < VIS_V);

    // Drive the active level for the whole blank; inactive while in reset.
    always_comb sync = (rst_n && !visible) ? ACTIVE_HIGH : ~ACTIVE_HIGH;
endmodule

// File: rtl/tft_pixel_gate.sv
// Forces the color to zero whenever the dot is not visible.
// Assumes: the enable is already qualified for reset.
module tft_pixel_gate #(
    parameter int CW = 9
) (
    input  logic          en,
    input  logic [CW-1:0] din,
    output logic [CW-1:0] dout
);
    // Pass the color or blank it.
    always_comb dout = en ? din : '0;
endmodule

// File: rtl/tft_raster_gen.sv
// Top level of the raster timing generator.
// Scans H_VIS+H_BLANK dots per line and V_VIS+V_BLANK lines per frame,
// one dot per clock, and publishes the position, the syncs, pix_en and
// the gated color.
// Assumes: clk is the panel dot clock and rst_n is synchronous and active low.
module tft_raster_gen #(
    parameter int H_VIS            = 240,
    parameter int H_BLANK          = 40,
    parameter int V_VIS            = 160,
    parameter int V_BLANK          = 10,
    parameter bit SYNC_ACTIVE_HIGH = 1'b0,
    parameter int CW               = tft_raster_pkg::cnt_w(H_VIS + H_BLANK),
    parameter int RW               = tft_raster_pkg::cnt_w(V_VIS + V_BLANK)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [tft_raster_pkg::COLOR_W-1:0] rgb_in,
    output logic                               hsync,
    output logic                               vsync,
    output logic [CW-1:0]                      col,
    output logic [RW-1:0]                      row,
    output logic                               pix_en,
    output logic [tft_raster_pkg::COLOR_W-1:0] rgb_out
);
    localparam int H_TOT = H_VIS + H_BLANK;
    localparam int V_TOT = V_VIS + V_BLANK;

    logic h_wrap, v_wrap, h_vis, v_vis;

    tft_axis_counter #(.LIMIT(H_TOT), .W(CW)) u_col (
        .clk(clk), .rst_n(rst_n), .adv(1'b1), .cnt(col), .wrap(h_wrap));

    tft_axis_counter #(.LIMIT(V_TOT), .W(RW)) u_row (
        .clk(clk), .rst_n(rst_n), .adv(h_wrap), .cnt(row), .wrap(v_wrap));

    tft_sync_decode #(.VIS(H_VIS), .W(CW), .ACTIVE_HIGH(SYNC_ACTIVE_HIGH)) u_hdec (
        .rst_n(rst_n), .pos(col), .visible(h_vis), .sync(hsync));

    tft_sync_decode #(.VIS(V_VIS), .W(RW), .ACTIVE_HIGH(SYNC_ACTIVE_HIGH)) u_vdec (
        .rst_n(rst_n), .pos(row), .visible(v_vis), .sync(vsync));

    // A dot is visible only inside both extents and outside reset.
    always_comb pix_en = rst_n && h_vis && v_vis;

    tft_pixel_gate #(.CW(tft_raster_pkg::COLOR_W)) u_gate (
        .en(pix_en), .din(rgb_in), .dout(rgb_out));
endmodule

// File: rtl/tft_raster_gen_chk.sv
// Checker for tft_raster_gen, attached to every instance through bind.
// Assumes: it sees the top-level ports and parameters.
module tft_raster_gen_chk #(
    parameter int H_VIS = 240, parameter int H_BLANK = 40,
    parameter int V_VIS = 160, parameter int V_BLANK = 10,
    parameter bit SYNC_ACTIVE_HIGH = 1'b0,
    parameter int CW = 9, parameter int RW = 8
) (
    input logic clk, rst_n, hsync, vsync, pix_en,
    input logic [CW-1:0] col,
    input logic [RW-1:0] row,
    input logic [8:0] rgb_in, rgb_out
);
    localparam int H_TOT = H_VIS + H_BLANK;
    localparam int V_TOT = V_VIS + V_BLANK;
    localparam logic ACT = SYNC_ACTIVE_HIGH;

    // R2
    col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col != CW'(H_TOT-1)) |=> (col == $past(col) + 1'b1));
    // R2
    col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col == CW'(H_TOT-1)) |=> (col == '0));
    // R3
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col != CW'(H_TOT-1)) |=> $stable(row));
    // R3
    row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col == CW'(H_TOT-1) && row == RW'(V_TOT-1)) |=> (row == '0));
    // R4
    hsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync == ACT) == (col >= CW'(H_VIS)));
    // R5
    vsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync == ACT) == (row >= RW'(V_VIS)));
    // R8
    blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |-> (rgb_out == '0));
    // R7
    pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en |-> (rgb_out == rgb_in));
endmodule

bind tft_raster_gen tft_raster_gen_chk #(
    .H_VIS(H_VIS), .H_BLANK(H_BLANK), .V_VIS(V_VIS), .V_BLANK(V_BLANK),
    .SYNC_ACTIVE_HIGH(SYNC_ACTIVE_HIGH), .CW(CW), .RW(RW)
) u_chk (.*);

// File: tb/tft_raster_gen_test.sv
// Sweeps whole frames of two small configurations, one per polarity,
// and compares every dot with a position model kept in the bench.
module tft_raster_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int HV = 6, HB = 3, VV = 4, VB = 2;
    localparam int HT = HV + HB, VT = VV + VB;

    logic clk = 0, rst_n = 0;
    logic [8:0] rgb_in = '0;
    logic hs0, vs0, pe0, hs1, vs1, pe1;
    logic [3:0] c0, c1;
    logic [2:0] r0, r1;
    logic [8:0] o0, o1;
    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tft_raster_gen #(.H_VIS(HV), .H_BLANK(HB), .V_VIS(VV), .V_BLANK(VB),
        .SYNC_ACTIVE_HIGH(1'b0), .CW(4), .RW(3)) uut (
        .clk(clk), .rst_n(rst_n), .rgb_in(rgb_in), .hsync(hs0), .vsync(vs0),
        .col(c0), .row(r0), .pix_en(pe0), .rgb_out(o0));

    tft_raster_gen #(.H_VIS(HV), .H_BLANK(HB), .V_VIS(VV), .V_BLANK(VB),
        .SYNC_ACTIVE_HIGH(1'b1), .CW(4), .RW(3)) uut_hi (
        .clk(clk), .rst_n(rst_n), .rgb_in(rgb_in), .hsync(hs1), .vsync(vs1),
        .col(c1), .row(r1), .pix_en(pe1), .rgb_out(o1));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare both instances against the model position (x,y).
    task automatic check_dot(input int x, input int y);
        bit vis;
        vis = (x < HV) && (y < VV);
        chk("R2 col", c0, x);             chk("R2 col hi", c1, x);
        chk("R3 row", r0, y);             chk("R3 row hi", r1, y);
        chk("R4 R9 hsync low-active", hs0, (x >= HV) ? 0 : 1);
        chk("R4 R9 hsync high-active", hs1, (x >= HV) ? 1 : 0);
        chk("R5 R9 vsync low-active", vs0, (y >= VV) ? 0 : 1);
        chk("R5 R9 vsync high-active", vs1, (y >= VV) ? 1 : 0);
        chk("R6 pix_en", pe0, vis);
        chk("R7 R8 R10 rgb_out", o0, vis ? rgb_in : 0);
        chk("R7 R8 rgb_out hi", o1, vis ? rgb_in : 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int x, y;
        rgb_in = 9'h1FF;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        // R1 reset state
        chk("R1 col", c0, 0); chk("R1 row", r0, 0);
        chk("R1 hsync", hs0, 1); chk("R1 vsync", vs0, 1);
        chk("R1 hsync hi", hs1, 0); chk("R1 vsync hi", vs1, 0);
        chk("R1 pix_en", pe0, 0); chk("R1 rgb_out", o0, 0);
        rst_n = 1;
        x = 0; y = 0;
        for (int n = 0; n < 3 * HT * VT + 5; n++) begin
            rgb_in = 9'((n * 37 + 5) & 9'h1FF);
            #1;
            check_dot(x, y);
            @(posedge clk);
            #(CLK_PERIOD/4);
            x++;
            if (x == HT) begin x = 0; y = (y + 1) % VT; end
        end
        // Mid-frame reset returns to origin.
        rst_n = 0;
        @(posedge clk); #(CLK_PERIOD/4);
        chk("R1 col after reset", c0, 0);
        chk("R1 row after reset", r0, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule